// File: doc/BRIEF.md
# Joinable Dual-Channel PWM Counter

This block holds two byte-wide pulse-width counters, a low-order channel and a high-order channel. Each has its own period and duty register. In split mode each channel counts on its own clock-enable strobe, returns to zero after it reaches its period, and drives its pin high while its count is below its duty value. A join input merges the two into one double-width counter. The low-order channel supplies the clock enable and drives the pin. The high-order channel supplies the upper byte of the count, period and duty, and its pin is released to general-purpose use.

Software reaches all six byte registers through one byte-wide access port with registered read data. A read of the upper count byte captures the lower byte at the same edge. A lower-byte read in the very next cycle returns that captured value, so a two-access read of the running 16-bit count always gives a consistent pair. A write to the lower count byte restarts the counter. A write to the upper count byte is ignored while the counters are joined.

Top module: `pwm_pair`

## Requirements
- R1: In split mode, each channel's count advances by one on each cycle its own enable is high, and it becomes 0 on the step after the count equals (or exceeds) its period register.
- R2: In joined mode the pair counts as one value {upper count, lower count} on the low-order enable alone. The high-order enable has no effect. The pair wraps to 0 after reaching {upper period, lower period}, and the upper byte advances when the lower byte passes 0xFF.
- R3: Pins are registered, one cycle after the count. In split mode both output enables are 1 and each pin is high while count < duty. In joined mode the low-order pin is high while the 16-bit count < {upper duty, lower duty}, and the high-order pin and its output enable are both 0.
- R4: A write to address 0 (lower count byte) makes the lower count 0, and in joined mode the upper count as well. This write takes priority over a count step in the same cycle.
- R5: A write to address 1 (upper count byte) leaves the count unchanged in joined mode. In split mode it makes the high-order channel's count 0 and leaves the low-order count unchanged.
- R6: A read of address 1 at one edge captures the lower count byte. A read of address 0 at the next edge returns that captured byte, not the live one.
- R7: A read of address 0 that does not directly follow a read of address 1 returns the live lower count.
- R8: While reset is held, both counts, the period and duty registers, the capture, read data, pins and output enables are 0, and the pair is in split mode.
- R9: Address map: 0 = lower count, 1 = upper count, 2 = lower period, 3 = upper period, 4 = lower duty, 5 = upper duty; 6 and 7 read as 0. Period and duty registers read back what was written. Read data appears after the edge that takes the read and holds until the next read.
- R10: The join input is sampled into a mode register at each edge. The high-order output enable follows the mode one further cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| join_i | input | 1 | 1 joins the two channels into one 16-bit counter |
| tick_lo_i | input | 1 | Count enable of the low-order channel |
| tick_hi_i | input | 1 | Count enable of the high-order channel (split mode only) |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| pin_lo_o | output | 1 | Low-order channel PWM output |
| pin_lo_oe_o | output | 1 | Low-order pin output enable |
| pin_hi_o | output | 1 | High-order channel PWM output |
| pin_hi_oe_o | output | 1 | High-order pin output enable; 0 when joined |

## Verification
Two collisions can fall in one cycle. One is a count step against a write to a count byte; the other is a count step against the upper-byte read whose lower byte must stay frozen. The bench holds the low-order enable high on the very edge of a lower-byte write and expects a zero count, not a count of one. It then reads the joined counter across a 0x00FF to 0x0100 carry with the enable still high, and expects the pair 0x00/0xFF rather than the torn 0x00/0x00. A control case puts an idle, counting cycle between the two reads and expects the live lower byte instead.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
   localparam int ADDR_W = 3;
   localparam int NUM_CH = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_CNT_LO  = 3'd0,
      RA_CNT_HI  = 3'd1,
      RA_PER_LO  = 3'd2,
      RA_PER_HI  = 3'd3,
      RA_DUTY_LO = 3'd4,
      RA_DUTY_HI = 3'd5
   } reg_addr_e;

   // channel index within packed per-channel vectors
   localparam int CH_LO = 0;
   localparam int CH_HI = 1;

   // register index (0 = period, 1 = duty) and channel for a config address
   function automatic logic cfg_is_duty(input logic [ADDR_W-1:0] a);
      return a[2];
   endfunction

   function automatic logic cfg_is_hi(input logic [ADDR_W-1:0] a);
      return a[0];
   endfunction

   function automatic logic addr_is_cfg(input logic [ADDR_W-1:0] a);
      return (a >= RA_PER_LO) && (a <= RA_DUTY_HI);
   endfunction
endpackage

// File: rtl/pwm_cnt_slice.sv
module pwm_cnt_slice #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          step_i,
   input  logic          wrap_i,
   output logic [DW-1:0] cnt_o
);
   initial begin
      if (DW < 2) $error("pwm_cnt_slice: DW must be at least 2");
   end

   logic [DW-1:0] cnt_q;
   logic [DW-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clr_i)       cnt_d = '0;
      else if (step_i) cnt_d = wrap_i ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
   import pwm_pair_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DW-1:0]              wdata_i,
   output logic [NUM_CH-1:0][DW-1:0]  per_o,
   output logic [NUM_CH-1:0][DW-1:0]  duty_o
);
   logic [NUM_CH-1:0][DW-1:0] per_q;
   logic [NUM_CH-1:0][DW-1:0] duty_q;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic hit;
      assign hit = wr_i && addr_is_cfg(addr_i) && (int'(cfg_is_hi(addr_i)) == ch);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_q[ch]  <= '0;
            duty_q[ch] <= '0;
         end else if (hit) begin
            if (cfg_is_duty(addr_i)) duty_q[ch] <= wdata_i;
            else                     per_q[ch]  <= wdata_i;
         end
      end
   end

   assign per_o  = per_q;
   assign duty_o = duty_q;
endmodule

// File: rtl/pwm_readback.sv
module pwm_readback
   import pwm_pair_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [NUM_CH-1:0][DW-1:0]  cnt_i,
   input  logic [NUM_CH-1:0][DW-1:0]  per_i,
   input  logic [NUM_CH-1:0][DW-1:0]  duty_i,
   output logic [DW-1:0]              rdata_o
);
   logic [DW-1:0] snap_q;
   logic          snap_vld_q;
   logic [DW-1:0] rdata_q;
   logic [DW-1:0] sel;
   logic          rd_hi;

   assign rd_hi = rd_i && (addr_i == RA_CNT_HI);

   always_comb begin
      unique case (addr_i)
         RA_CNT_LO:  sel = snap_vld_q ? snap_q : cnt_i[CH_LO];
         RA_CNT_HI:  sel = cnt_i[CH_HI];
         RA_PER_LO:  sel = per_i[CH_LO];
         RA_PER_HI:  sel = per_i[CH_HI];
         RA_DUTY_LO: sel = duty_i[CH_LO];
         RA_DUTY_HI: sel = duty_i[CH_HI];
         default:    sel = '0;
      endcase
   end

   // capture lives exactly one cycle after an upper-byte read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q     <= '0;
         snap_vld_q <= 1'b0;
      end else begin
         snap_vld_q <= rd_hi;
         if (rd_hi) snap_q <= cnt_i[CH_LO];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= sel;
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
   import pwm_pair_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       joined_i,
   input  logic [NUM_CH-1:0][DW-1:0]  cnt_i,
   input  logic [NUM_CH-1:0][DW-1:0]  duty_i,
   output logic                       pin_lo_o,
   output logic                       pin_lo_oe_o,
   output logic                       pin_hi_o,
   output logic                       pin_hi_oe_o
);
   localparam int WW = 2 * DW;

   logic [WW-1:0] cnt_w, duty_w;
   logic [NUM_CH-1:0] on_split;
   logic on_lo, on_hi;
   logic pin_lo_q, pin_hi_q, oe_lo_q, oe_hi_q;

   assign cnt_w  = {cnt_i[CH_HI],  cnt_i[CH_LO]};
   assign duty_w = {duty_i[CH_HI], duty_i[CH_LO]};

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
      assign on_split[ch] = cnt_i[ch] < duty_i[ch];
   end

   assign on_lo = joined_i ? (cnt_w < duty_w) : on_split[CH_LO];
   assign on_hi = joined_i ? 1'b0 : on_split[CH_HI];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_lo_q <= 1'b0;
         pin_hi_q <= 1'b0;
         oe_lo_q  <= 1'b0;
         oe_hi_q  <= 1'b0;
      end else begin
         pin_lo_q <= on_lo;
         pin_hi_q <= on_hi;
         oe_lo_q  <= 1'b1;
         oe_hi_q  <= !joined_i;
      end
   end

   assign pin_lo_o    = pin_lo_q;
   assign pin_hi_o    = pin_hi_q;
   assign pin_lo_oe_o = oe_lo_q;
   assign pin_hi_oe_o = oe_hi_q;
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
   import pwm_pair_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              join_i,
   input  logic              tick_lo_i,
   input  logic              tick_hi_i,
   input  logic              bus_en_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DW-1:0]     bus_wdata_i,
   output logic [DW-1:0]     bus_rdata_o,
   output logic              pin_lo_o,
   output logic              pin_lo_oe_o,
   output logic              pin_hi_o,
   output logic              pin_hi_oe_o
);
   localparam int WW = 2 * DW;

   initial begin
      if (DW != 8) $error("pwm_pair: register port is byte wide, DW must be 8");
   end

   logic joined_q;
   logic wr, rd, wr_cnt_lo, wr_cnt_hi;
   logic [NUM_CH-1:0][DW-1:0] cnt, per, duty;
   logic [NUM_CH-1:0] clr, step, wrap;
   logic [WW-1:0] cnt_w, per_w;
   logic wrap_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) joined_q <= 1'b0;
      else        joined_q <= join_i;
   end

   assign wr        = bus_en_i && bus_we_i;
   assign rd        = bus_en_i && !bus_we_i;
   assign wr_cnt_lo = wr && (bus_addr_i == RA_CNT_LO);
   assign wr_cnt_hi = wr && (bus_addr_i == RA_CNT_HI);

   assign cnt_w  = {cnt[CH_HI], cnt[CH_LO]};
   assign per_w  = {per[CH_HI], per[CH_LO]};
   assign wrap_w = cnt_w >= per_w;

   // per-slice controls: split mode uses own strobe, joined mode chains
   always_comb begin
      clr[CH_LO]  = wr_cnt_lo;
      step[CH_LO] = tick_lo_i;
      wrap[CH_LO] = joined_q ? wrap_w : (cnt[CH_LO] >= per[CH_LO]);
      if (joined_q) begin
         clr[CH_HI]  = wr_cnt_lo;
         step[CH_HI] = tick_lo_i && (wrap_w || (cnt[CH_LO] == '1));
         wrap[CH_HI] = wrap_w;
      end else begin
         clr[CH_HI]  = wr_cnt_hi;
         step[CH_HI] = tick_hi_i;
         wrap[CH_HI] = cnt[CH_HI] >= per[CH_HI];
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slice
      pwm_cnt_slice #(.DW(DW)) u_slice (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr_i  (clr[ch]),
         .step_i (step[ch]),
         .wrap_i (wrap[ch]),
         .cnt_o  (cnt[ch])
      );
   end

   pwm_cfg_regs #(.DW(DW)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .per_o   (per),
      .duty_o  (duty)
   );

   pwm_readback #(.DW(DW)) u_rb (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_i    (rd),
      .addr_i  (bus_addr_i),
      .cnt_i   (cnt),
      .per_i   (per),
      .duty_i  (duty),
      .rdata_o (bus_rdata_o)
   );

   pwm_out_stage #(.DW(DW)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .joined_i    (joined_q),
      .cnt_i       (cnt),
      .duty_i      (duty),
      .pin_lo_o    (pin_lo_o),
      .pin_lo_oe_o (pin_lo_oe_o),
      .pin_hi_o    (pin_hi_o),
      .pin_hi_oe_o (pin_hi_oe_o)
   );
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
   import pwm_pair_pkg::*;
#(
   parameter int DW = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       joined_q,
   input logic                       tick_lo_i,
   input logic                       bus_en_i,
   input logic                       bus_we_i,
   input logic [ADDR_W-1:0]          bus_addr_i,
   input logic [DW-1:0]              bus_rdata_o,
   input logic [NUM_CH-1:0][DW-1:0]  cnt,
   input logic [NUM_CH-1:0][DW-1:0]  per,
   input logic                       pin_hi_o,
   input logic                       pin_hi_oe_o
);
   logic wr_lo, wr_hi, rd_lo, rd_hi;
   assign wr_lo = bus_en_i && bus_we_i && (bus_addr_i == RA_CNT_LO);
   assign wr_hi = bus_en_i && bus_we_i && (bus_addr_i == RA_CNT_HI);
   assign rd_lo = bus_en_i && !bus_we_i && (bus_addr_i == RA_CNT_LO);
   assign rd_hi = bus_en_i && !bus_we_i && (bus_addr_i == RA_CNT_HI);

   // R1: split-mode lower channel steps by one below its period
   a_r1_split_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!joined_q && tick_lo_i && !wr_lo && (cnt[CH_LO] < per[CH_LO]))
      |=> (cnt[CH_LO] == $past(cnt[CH_LO]) + 1'b1));

   // R2: joined mode carries into the upper byte when lower byte passes all-ones
   a_r2_joined_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (joined_q && tick_lo_i && !wr_lo && (cnt[CH_LO] == '1)
       && ({cnt[CH_HI], cnt[CH_LO]} < {per[CH_HI], per[CH_LO]}))
      |=> (cnt[CH_HI] == $past(cnt[CH_HI]) + 1'b1) && (cnt[CH_LO] == '0));

   // R3: joined mode releases the high-order pin
   a_r3_hi_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
      joined_q |=> (!pin_hi_oe_o && !pin_hi_o));

   // R4: lower-byte write wins over a count step
   a_r4_lo_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (cnt[CH_LO] == '0) && (!$past(joined_q) || (cnt[CH_HI] == '0)));

   // R5: upper-byte write ignored when joined
   a_r5_hi_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (joined_q && wr_hi && !tick_lo_i) |=> $stable(cnt));

   // R6: lower read right after upper read returns the captured byte
   a_r6_coherent_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && $past(rd_hi)) |=> (bus_rdata_o == $past(cnt[CH_LO], 2)));
endmodule

bind pwm_pair pwm_pair_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .joined_q    (joined_q),
   .tick_lo_i   (tick_lo_i),
   .bus_en_i    (bus_en_i),
   .bus_we_i    (bus_we_i),
   .bus_addr_i  (bus_addr_i),
   .bus_rdata_o (bus_rdata_o),
   .cnt         (cnt),
   .per         (per),
   .pin_hi_o    (pin_hi_o),
   .pin_hi_oe_o (pin_hi_oe_o)
);

// File: tb/pwm_pair_test.sv
module pwm_pair_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       join_i = 1'b0;
   logic       tick_lo_i = 1'b0;
   logic       tick_hi_i = 1'b0;
   logic       bus_en_i = 1'b0;
   logic       bus_we_i = 1'b0;
   logic [2:0] bus_addr_i = '0;
   logic [7:0] bus_wdata_i = '0;
   logic [7:0] bus_rdata_o;
   logic       pin_lo_o, pin_lo_oe_o, pin_hi_o, pin_hi_oe_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   pwm_pair uut (.*);

   always #5 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_en_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_en_i = 0; bus_we_i = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_en_i = 1; bus_we_i = 0; bus_addr_i = a;
      @(negedge clk);
      bus_en_i = 0;
      d = bus_rdata_o;
   endtask

   task automatic tick(input bit lo, input bit hi, input int n);
      tick_lo_i = lo; tick_hi_i = hi;
      for (int i = 0; i < n; i++) @(negedge clk);
      tick_lo_i = 0; tick_hi_i = 0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R8 rdata", bus_rdata_o, 0);
      chk("R8 pins", {pin_lo_o, pin_lo_oe_o, pin_hi_o, pin_hi_oe_o}, 0);
      rst_n = 1;
      idle(1);
      rd(3'd0, d); chk("R8 cnt lo", d, 0);
      rd(3'd5, d); chk("R8 duty hi", d, 0);
   endtask

   task automatic t_regmap();
      logic [7:0] d;
      wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'h44);
      rd(3'd2, d); chk("R9 per lo", d, 8'h11);
      rd(3'd3, d); chk("R9 per hi", d, 8'h22);
      rd(3'd4, d); chk("R9 duty lo", d, 8'h33);
      rd(3'd5, d); chk("R9 duty hi", d, 8'h44);
      idle(2);     chk("R9 rdata holds", bus_rdata_o, 8'h44);
      rd(3'd6, d); chk("R9 unused addr", d, 0);
   endtask

   task automatic t_split_count();
      logic [7:0] d;
      wr(3'd2, 8'd3); wr(3'd3, 8'd10);
      wr(3'd0, 8'h00); wr(3'd1, 8'h00);
      tick(1, 0, 5);
      rd(3'd0, d); chk("R1 lo wraps past period 3", d, 1);
      tick(0, 1, 5);
      rd(3'd1, d); chk("R1 hi counts own enable", d, 5);
      idle(1);
      rd(3'd0, d); chk("R1 lo untouched by hi enable", d, 1);
      // R5: split-mode upper write clears only high channel
      wr(3'd1, 8'hAA);
      rd(3'd1, d); chk("R5 split hi write clears hi", d, 0);
      rd(3'd0, d); chk("R5 split hi write keeps lo", d, 1);
      // R4: lower write and step in the same cycle -> zero
      tick_lo_i = 1;
      wr(3'd0, 8'h55);
      tick_lo_i = 0;
      rd(3'd0, d); chk("R4 write beats step", d, 0);
   endtask

   task automatic t_split_pins();
      wr(3'd2, 8'd9); wr(3'd3, 8'd9);
      wr(3'd4, 8'd2); wr(3'd5, 8'd1);
      wr(3'd0, 0); wr(3'd1, 0);
      idle(2);
      chk("R3 split lo pin cnt0<2", pin_lo_o, 1);
      chk("R3 split hi pin cnt0<1", pin_hi_o, 1);
      chk("R3 split oe", {pin_lo_oe_o, pin_hi_oe_o}, 2'b11);
      tick(1, 1, 2);
      idle(1);
      chk("R3 split lo pin cnt2", pin_lo_o, 0);
      chk("R3 split hi pin cnt2", pin_hi_o, 0);
   endtask

   task automatic t_join();
      logic [7:0] h, l;
      join_i = 1;
      @(negedge clk);
      chk("R10 hi oe one cycle late", pin_hi_oe_o, 1);
      @(negedge clk);
      chk("R10 hi oe released", pin_hi_oe_o, 0);
      wr(3'd2, 8'h05); wr(3'd3, 8'h01);
      wr(3'd4, 8'h03); wr(3'd5, 8'h01);
      tick(0, 1, 3);
      wr(3'd0, 0);
      rd(3'd1, h); chk("R4 joined lo write clears hi", h, 0);
      tick(1, 0, 258);
      tick(0, 1, 4);
      rd(3'd1, h); rd(3'd0, l);
      chk("R2 joined count 0x102", {h, l}, 16'h0102);
      idle(1);
      chk("R3 joined lo pin 0x102<0x103", pin_lo_o, 1);
      chk("R3 joined hi pin off", {pin_hi_o, pin_hi_oe_o}, 0);
      wr(3'd1, 8'h77);
      rd(3'd1, h); rd(3'd0, l);
      chk("R5 joined hi write ignored", {h, l}, 16'h0102);
      tick(1, 0, 3);
      rd(3'd1, h); rd(3'd0, l);
      chk("R2 joined at period", {h, l}, 16'h0105);
      idle(1);
      chk("R3 joined lo pin 0x105", pin_lo_o, 0);
      tick(1, 0, 1);
      rd(3'd1, h); rd(3'd0, l);
      chk("R2 joined wrap", {h, l}, 0);
   endtask

   task automatic t_coherent();
      logic [7:0] h, l;
      wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      wr(3'd0, 0);
      tick(1, 0, 255);
      // read across the 0x00FF -> 0x0100 carry, counting throughout
      tick_lo_i = 1;
      bus_en_i = 1; bus_we_i = 0; bus_addr_i = 3'd1;
      @(negedge clk);
      h = bus_rdata_o;
      bus_addr_i = 3'd0;
      @(negedge clk);
      l = bus_rdata_o;
      bus_en_i = 0; tick_lo_i = 0;
      chk("R6 coherent pair", {h, l}, 16'h00FF);
      // now count = 0x0101; read hi, count one idle cycle, read lo live
      rd(3'd1, h);
      tick(1, 0, 1);
      rd(3'd0, l);
      chk("R7 stale capture not used", l, 8'h02);
   endtask

   initial begin
      idle(3);
      t_reset();
      t_regmap();
      t_split_count();
      t_split_pins();
      t_join();
      t_coherent();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule